// File: doc/BRIEF.md
# Serial Controller Interrupt Mask and Status Unit

This unit collects the event indications of a serial controller (receiver, transmitter and FIFO conditions) and turns them into one interrupt request. Software controls which events may interrupt through a mask. The mask is never written directly. One write port turns mask bits on and a second write port turns them off, so a driver can change one source without a read-modify-write. An event whose mask bit is on is latched into a sticky status register. It stays there until software clears it by writing a 1 to that bit. A separate channel view shows the live event inputs whatever the mask holds, so software can poll conditions it has chosen not to take as interrupts.

The event bit positions are fixed, because the event generator and software both decode them:
- bit 0: receive trigger level reached
- bit 1: receive FIFO empty
- bit 2: receive FIFO full
- bit 3: transmit FIFO empty
- bit 4: transmit FIFO full
- bit 5: receive overrun
- bit 6: framing error
- bit 7: parity error
- bit 8: receive timeout

Registers are 13 bits wide. Bits 12 to 9 always read as zero and ignore writes. A write is one cycle with `wr_en_i` high, taking effect at that clock edge. Reads are combinational from `rd_addr_i`.

The unit has no sequencing states. Its behaviour is fully described by its three registers (mask, status, request) and the decode of the register select:
- 0: enable, write-one-to-set
- 1: disable, write-one-to-clear
- 2: mask, read-only
- 3: status, write-one-to-clear
- 4: channel view, read-only
- 5 to 7: unused

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask, the status and `irq_o` are zero, and every register select reads zero except the channel view, which reflects the event inputs.
- R2: A write to select 0 sets each mask bit whose data bit is 1 and leaves mask bits whose data bit is 0 unchanged. Select 2 reads back the mask.
- R3: A write to select 1 clears each mask bit whose data bit is 1 and leaves the others unchanged.
- R4: Selects 0 and 1 read as zero. Writes to selects 2, 4, 5, 6 and 7 change neither the mask nor the status.
- R5: An event input bit that is high at a clock edge sets its status bit only if its mask bit is 1. Select 3 reads back the status.
- R6: Status bits are sticky. A write to select 3 clears each status bit whose data bit is 1, and zero data bits leave status unchanged.
- R7: When a status clear and a new unmasked event hit the same bit in the same cycle, the bit stays set.
- R8: Select 4 returns the current event inputs in bits 8..0, independent of the mask.
- R9: Bits 12..9 read zero on every select, and writing 1 to them has no effect.
- R10: `irq_o` is a register. It goes high one clock after a status bit with its mask bit set exists, and goes low one clock after no such bit remains. Clearing the mask bit therefore hides a pending status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 3 | Register select for the write |
| wr_data_i | input | 13 | Write data |
| rd_addr_i | input | 3 | Register select for the read |
| rd_data_o | output | 13 | Read data, combinational |
| evt_i | input | 9 | Event inputs from receiver, transmitter and FIFOs |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a status clear landing in the very cycle a fresh unmasked event hits the same bit. Only that collision can show whether the event or the clear takes priority. A directed step raises the event and writes the clear in one cycle. The random phase also produces such collisions often, because events and status-clear writes are drawn independently each cycle. A second delicate case is a latched status bit whose mask bit is later removed, so the request must fall while status stays set. The stimulus builds it deliberately and then checks both views.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int unsigned SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_ENA  = 3'd0,
        SEL_DIS  = 3'd1,
        SEL_MASK = 3'd2,
        SEL_STAT = 3'd3,
        SEL_CHAN = 3'd4
    } irq_sel_e;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int unsigned N = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         set_en_i,
    input  logic         clr_en_i,
    input  logic [N-1:0] bits_i,
    output logic [N-1:0] mask_o
);
    logic [N-1:0] mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else if (set_en_i) begin
            mask_q <= mask_q | bits_i;
        end else if (clr_en_i) begin
            mask_q <= mask_q & ~bits_i;
        end
    end

    assign mask_o = mask_q;

    p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_en_i |=> ((mask_q & $past(bits_i)) == $past(bits_i)));
    p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_en_i |=> ((mask_q & $past(bits_i)) == '0));
    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_en_i && !clr_en_i) |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned N = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_en_i,
    input  logic [N-1:0] clr_bits_i,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] stat_o,
    output logic         irq_o
);
    logic [N-1:0] stat_q;
    logic [N-1:0] hit;
    logic [N-1:0] wipe;
    logic         irq_q;

    always_comb begin
        hit  = evt_i & mask_i;
        wipe = clr_en_i ? clr_bits_i : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~wipe) | hit;
            irq_q  <= |(stat_q & mask_i);
        end
    end

    assign stat_o = stat_q;
    assign irq_o  = irq_q;

    p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (((stat_q & ~$past(stat_q)) & ~$past(mask_i)) == '0));
    p_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stat_q & $past(hit)) == $past(hit)));
    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_en_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    p_wipe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_en_i |=> ((stat_q & $past(clr_bits_i & ~hit)) == '0));
endmodule

// File: rtl/irq_read_sel.sv
module irq_read_sel
    import uart_irq_pkg::*;
#(
    parameter int unsigned N     = 9,
    parameter int unsigned REG_W = 13
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N-1:0]     mask_i,
    input  logic [N-1:0]     stat_i,
    input  logic [N-1:0]     evt_i,
    output logic [REG_W-1:0] data_o
);
    logic [N-1:0] pick;

    always_comb begin
        unique case (sel_i)
            SEL_MASK: pick = mask_i;
            SEL_STAT: pick = stat_i;
            SEL_CHAN: pick = evt_i;
            default:  pick = '0;
        endcase
    end

    generate
        if (REG_W > N) begin : g_pad
            assign data_o = {{(REG_W-N){1'b0}}, pick};
        end else begin : g_nopad
            assign data_o = pick[REG_W-1:0];
        end
    endgenerate

    always_comb begin
        p_pad_r9: assert (data_o >> N == '0);
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 9,
    parameter int unsigned REG_W   = 13
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [SEL_W-1:0]     wr_addr_i,
    input  logic [REG_W-1:0]     wr_data_i,
    input  logic [SEL_W-1:0]     rd_addr_i,
    output logic [REG_W-1:0]     rd_data_o,
    input  logic [NUM_SRC-1:0]   evt_i,
    output logic                 irq_o
);
    logic               ena_wr, dis_wr, stat_wr;
    logic [NUM_SRC-1:0] wbits, mask, stat;

    always_comb begin
        ena_wr  = wr_en_i && (wr_addr_i == SEL_ENA);
        dis_wr  = wr_en_i && (wr_addr_i == SEL_DIS);
        stat_wr = wr_en_i && (wr_addr_i == SEL_STAT);
        wbits   = wr_data_i[NUM_SRC-1:0];
    end

    irq_mask_bank #(.N(NUM_SRC)) u_mask (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_en_i (ena_wr),
        .clr_en_i (dis_wr),
        .bits_i   (wbits),
        .mask_o   (mask)
    );

    irq_status_bank #(.N(NUM_SRC)) u_stat (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_en_i   (stat_wr),
        .clr_bits_i (wbits),
        .evt_i      (evt_i),
        .mask_i     (mask),
        .stat_o     (stat),
        .irq_o      (irq_o)
    );

    irq_read_sel #(.N(NUM_SRC), .REG_W(REG_W)) u_rd (
        .sel_i  (rd_addr_i),
        .mask_i (mask),
        .stat_i (stat),
        .evt_i  (evt_i),
        .data_o (rd_data_o)
    );

    p_irq_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(stat != '0));
    p_irq_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat == '0) |=> !irq_o);
    p_blind_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i || wr_addr_i > SEL_STAT) |=> $stable(mask));
endmodule

// File: tb/test_uart_irq_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_ctrl;
    localparam int N = 9;
    localparam int W = 13;
    localparam logic [N-1:0] VALID = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic [N-1:0] evt = '0;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [N-1:0] m_mask = '0;
    logic [N-1:0] m_stat = '0;
    logic         m_irq  = 1'b0;

    always #2 clk = ~clk;

    uart_irq_ctrl i_uart_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .evt_i(evt), .irq_o(irq)
    );

    function automatic logic [W-1:0] exp_rd(input int a);
        case (a)
            2: return W'(m_mask);
            3: return W'(m_stat);
            4: return W'(evt);
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0, 1: return "R4";
            2: return "R2";
            3: return "R6";
            4: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.1;
            chk((tag == "") ? tag_of(a) : tag, rd_data, exp_rd(a));
        end
        chk((tag == "") ? "R10" : tag, W'(irq), W'(m_irq));
    endtask

    task automatic cyc(input logic we, input logic [2:0] wa, input logic [W-1:0] wd,
                       input logic [N-1:0] ev);
        logic [N-1:0] b;
        wr_en = we; wr_addr = wa; wr_data = wd; evt = ev;
        @(posedge clk);
        b = wd[N-1:0];
        m_irq  = |(m_stat & m_mask);
        m_stat = (m_stat & ~((we && wa == 3'd3) ? b : '0)) | (ev & m_mask);
        if (we && wa == 3'd0) m_mask = m_mask | b;
        else if (we && wa == 3'd1) m_mask = m_mask & ~b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog: got %0d expected below 100000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: set bits, zeros leave others alone
        cyc(1, 3'd0, 13'h0A5, '0);
        rd_addr = 3'd2; #0.1; chk("R2", rd_data, 13'h0A5);
        cyc(1, 3'd0, 13'h100, '0);
        rd_addr = 3'd2; #0.1; chk("R2", rd_data, 13'h1A5);
        // R3: clear bits
        cyc(1, 3'd1, 13'h005, '0);
        rd_addr = 3'd2; #0.1; chk("R3", rd_data, 13'h1A0);
        // R4: writes to read-only selects are ignored; write ports read zero
        cyc(1, 3'd2, 13'h1FFF, '0);
        cyc(1, 3'd4, 13'h1FFF, '0);
        cyc(1, 3'd6, 13'h1FFF, '0);
        rd_addr = 3'd2; #0.1; chk("R4", rd_data, 13'h1A0);
        rd_addr = 3'd0; #0.1; chk("R4", rd_data, 13'h000);
        rd_addr = 3'd1; #0.1; chk("R4", rd_data, 13'h000);
        // R9: upper bits ignored on write
        cyc(1, 3'd0, 13'h1E00, '0);
        rd_addr = 3'd2; #0.1; chk("R9", rd_data, 13'h1A0);
        // R5 and R8: masked-out events do not latch but show in the live view
        cyc(0, 3'd0, '0, 9'h003);
        rd_addr = 3'd3; #0.1; chk("R5", rd_data, 13'h000);
        rd_addr = 3'd4; #0.1; chk("R8", rd_data, 13'h003);
        chk("R10", W'(irq), 13'h0);
        // R5: unmasked event latches; R10: request one cycle later
        cyc(0, 3'd0, '0, 9'h020);
        rd_addr = 3'd3; #0.1; chk("R5", rd_data, 13'h020);
        chk("R10", W'(irq), 13'h0);
        cyc(0, 3'd0, '0, 9'h000);
        chk("R10", W'(irq), 13'h1);
        rd_addr = 3'd3; #0.1; chk("R6", rd_data, 13'h020);
        // R7: clear and event in the same cycle keeps the bit
        cyc(1, 3'd3, 13'h020, 9'h020);
        rd_addr = 3'd3; #0.1; chk("R7", rd_data, 13'h020);
        // R6: a zero data bit leaves status alone, then a real clear
        cyc(1, 3'd3, 13'h000, 9'h000);
        rd_addr = 3'd3; #0.1; chk("R6", rd_data, 13'h020);
        cyc(1, 3'd3, 13'h020, 9'h000);
        rd_addr = 3'd3; #0.1; chk("R6", rd_data, 13'h000);
        cyc(0, 3'd0, '0, 9'h000);
        chk("R10", W'(irq), 13'h0);
        // R10: removing the mask hides a pending status bit
        cyc(0, 3'd0, '0, 9'h100);
        cyc(1, 3'd1, 13'h100, 9'h000);
        chk("R10", W'(irq), 13'h1);
        cyc(0, 3'd0, '0, 9'h000);
        chk("R10", W'(irq), 13'h0);
        rd_addr = 3'd3; #0.1; chk("R6", rd_data, 13'h100);
        check_all("");

        // random phase: R2 R3 R4 R5 R6 R7 R8 R10 against the bench model
        for (int i = 0; i < 400; i++) begin
            logic [N-1:0] ev;
            ev = N'($urandom) & N'($urandom) & N'($urandom);
            cyc(($urandom % 3) != 0, 3'($urandom), W'($urandom), ev);
            check_all("");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule